// File: doc/BRIEF.md
# Flash Block Write-Protection Gate

This block sits in front of a flash program/erase controller. It screens every program, erase or suspend request before the controller acts on it. The array holds four equal 64 KiB blocks, selected by the two top bits of an 18-bit byte address. The highest block is the top block and the other three are the main blocks.

The gate weighs several inputs for each request: two active-low hardware protect pins, a per-block software lock register, a programming-voltage-valid flag and the controller's busy state. It then gives exactly one registered outcome, one cycle after the request. The outcome is a grant, which forwards the address, a silent ignore, or a voltage error. A voltage error also sets a sticky status bit, which stays set until reset or an explicit clear. Either of two active-low reset inputs resets the block and returns it to its idle read state.

Top module: `fwp_gate`

## Requirements
- R1: The target block is address bits 17:16; block 3 is the top block and blocks 0 to 2 are the main blocks. Each outcome appears on the outputs in the cycle after the clock edge that samples `req_vld`.
- R2: With `top_lock_n` low, a program (kind 0) or erase (kind 1) aimed at block 3 is ignored whatever the lock register holds; `top_lock_n` never changes the outcome for blocks 0 to 2.
- R3: With `main_wp_n` low, a program or erase aimed at blocks 0 to 2 is ignored whatever the lock register holds; `main_wp_n` never changes the outcome for block 3.
- R4: When the governing pin is high, lock bit i (1 = locked), written as a whole vector through `lock_we`/`lock_wdata`, decides: a locked block ignores the request and an unlocked one lets it go on.
- R5: A program or erase that passes protection while `vpp_ok` is low gives a one-cycle `verr` pulse, sets `verr_sticky` and gives no grant.
- R6: While `ctl_busy` is high, program and erase requests are ignored and a suspend (kind 2) is granted. A suspend while idle is ignored, as is kind 3.
- R7: Every request gives exactly one of grant, ignore or verr, and no cycle without a request gives any of them. Precedence runs busy, then protection, then voltage, so a refused request never raises verr.
- R8: `verr_sticky` falls only on reset or a `sts_clr` strobe. When an error and `sts_clr` meet on the same edge, the bit stays set.
- R9: The block is in reset while `rst_if_n` or `rst_cpu_n` is low. Reset clears all outcome outputs, the sticky bit and the lock register, which leaves every block unlocked.
- R10: On a grant, `grant_addr` carries the full request address. The pins and `vpp_ok` count only as sampled on the request edge, so a later change does not alter that outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_if_n | input | 1 | Interface reset, active low |
| rst_cpu_n | input | 1 | CPU reset, active low |
| req_vld | input | 1 | Request strobe, one cycle per request |
| req_kind | input | 2 | 0 program, 1 erase, 2 suspend, 3 reserved |
| req_addr | input | 18 | Byte address of the request |
| top_lock_n | input | 1 | Top block protect pin, active low |
| main_wp_n | input | 1 | Main blocks protect pin, active low |
| lock_we | input | 1 | Lock register write strobe |
| lock_wdata | input | 4 | New lock vector, bit i locks block i |
| vpp_ok | input | 1 | Programming voltage above lockout |
| ctl_busy | input | 1 | Controller busy with program or erase |
| sts_clr | input | 1 | Clear-status strobe |
| grant | output | 1 | Request may proceed (one cycle) |
| grant_addr | output | 18 | Address of the granted request, 0 otherwise |
| ignore | output | 1 | Request silently dropped (one cycle) |
| verr | output | 1 | Request refused for low voltage (one cycle) |
| verr_sticky | output | 1 | Sticky voltage error status bit |

## Verification
A request that fails on voltage can arrive on the same edge as a clear-status strobe. That edge both sets and clears the sticky bit. The bench drives a low-voltage program request together with `sts_clr` in one cycle. It expects the `verr` pulse and a sticky bit that stays high, then checks that a plain clear on a later cycle drops it. Busy and low voltage together are also driven in one cycle, and the result must be an ignore with no error.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
   typedef enum logic [1:0] {
      K_PROG  = 2'd0,
      K_ERASE = 2'd1,
      K_SUSP  = 2'd2,
      K_RSVD  = 2'd3
   } req_kind_e;

   typedef enum logic [1:0] {
      O_NONE   = 2'd0,
      O_GRANT  = 2'd1,
      O_IGNORE = 2'd2,
      O_VERR   = 2'd3
   } outcome_e;
endpackage

// File: rtl/fwp_lock_reg.sv
module fwp_lock_reg #(
   parameter int NBLK = 4
) (
   input  logic            clk,
   input  logic            srst,
   input  logic            we,
   input  logic [NBLK-1:0] wdata,
   output logic [NBLK-1:0] q
);
   always_ff @(posedge clk) begin
      if (srst)    q <= '0;
      else if (we) q <= wdata;
   end
endmodule

// File: rtl/fwp_prot_eval.sv
module fwp_prot_eval #(
   parameter int BLK_W = 2,
   localparam int NBLK = 1 << BLK_W
) (
   input  logic [BLK_W-1:0] blk_sel,
   input  logic             top_pin_n,
   input  logic             main_pin_n,
   input  logic [NBLK-1:0]  lock_q,
   output logic             blocked
);
   logic [NBLK-1:0] pin_ok;
   logic [NBLK-1:0] allow;

   for (genvar i = 0; i < NBLK; i++) begin : g_blk
      if (i == NBLK - 1) begin : g_top
         assign pin_ok[i] = top_pin_n;
      end else begin : g_main
         assign pin_ok[i] = main_pin_n;
      end
   end

   assign allow   = pin_ok & ~lock_q;
   assign blocked = ~allow[blk_sel];
endmodule

// File: rtl/fwp_status.sv
module fwp_status (
   input  logic clk,
   input  logic srst,
   input  logic set,
   input  logic clr,
   output logic sticky
);
   always_ff @(posedge clk) begin
      if (srst)     sticky <= 1'b0;
      else if (set) sticky <= 1'b1;
      else if (clr) sticky <= 1'b0;
   end
endmodule

// File: rtl/fwp_gate.sv
module fwp_gate #(
   parameter int ADDR_W = 18,
   parameter int BLK_W  = 2,
   localparam int NBLK  = 1 << BLK_W
) (
   input  logic              clk,
   input  logic              rst_if_n,
   input  logic              rst_cpu_n,
   input  logic              req_vld,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              top_lock_n,
   input  logic              main_wp_n,
   input  logic              lock_we,
   input  logic [NBLK-1:0]   lock_wdata,
   input  logic              vpp_ok,
   input  logic              ctl_busy,
   input  logic              sts_clr,
   output logic              grant,
   output logic [ADDR_W-1:0] grant_addr,
   output logic              ignore,
   output logic              verr,
   output logic              verr_sticky
);
   import fwp_pkg::*;

   if (ADDR_W <= BLK_W) begin : g_bad_addr
      $error("fwp_gate: ADDR_W must exceed BLK_W");
   end
   if (BLK_W < 1) begin : g_bad_blk
      $error("fwp_gate: BLK_W must be at least 1");
   end

   logic              srst;
   logic [BLK_W-1:0]  blk_sel;
   logic [NBLK-1:0]   lock_q;
   logic              blocked;
   req_kind_e         kind;
   outcome_e          nxt;

   assign srst    = ~(rst_if_n & rst_cpu_n);
   assign blk_sel = req_addr[ADDR_W-1 -: BLK_W];
   assign kind    = req_kind_e'(req_kind);

   fwp_lock_reg #(.NBLK(NBLK)) u_lock (
      .clk   (clk),
      .srst  (srst),
      .we    (lock_we),
      .wdata (lock_wdata),
      .q     (lock_q)
   );

   fwp_prot_eval #(.BLK_W(BLK_W)) u_eval (
      .blk_sel    (blk_sel),
      .top_pin_n  (top_lock_n),
      .main_pin_n (main_wp_n),
      .lock_q     (lock_q),
      .blocked    (blocked)
   );

   always_comb begin
      nxt = O_NONE;
      if (req_vld) begin
         unique case (kind)
            K_SUSP:          nxt = ctl_busy ? O_GRANT : O_IGNORE;
            K_PROG, K_ERASE: begin
               if (ctl_busy)     nxt = O_IGNORE;
               else if (blocked) nxt = O_IGNORE;
               else if (!vpp_ok) nxt = O_VERR;
               else              nxt = O_GRANT;
            end
            default:         nxt = O_IGNORE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (srst) begin
         grant      <= 1'b0;
         ignore     <= 1'b0;
         verr       <= 1'b0;
         grant_addr <= '0;
      end else begin
         grant      <= (nxt == O_GRANT);
         ignore     <= (nxt == O_IGNORE);
         verr       <= (nxt == O_VERR);
         grant_addr <= (nxt == O_GRANT) ? req_addr : '0;
      end
   end

   fwp_status u_sts (
      .clk    (clk),
      .srst   (srst),
      .set    (nxt == O_VERR),
      .clr    (sts_clr),
      .sticky (verr_sticky)
   );
endmodule

// File: rtl/fwp_gate_chk.sv
module fwp_gate_chk #(
   parameter int ADDR_W = 18,
   parameter int BLK_W  = 2,
   localparam int NBLK  = 1 << BLK_W
) (
   input logic              clk,
   input logic              rst_if_n,
   input logic              rst_cpu_n,
   input logic              req_vld,
   input logic [1:0]        req_kind,
   input logic [ADDR_W-1:0] req_addr,
   input logic              top_lock_n,
   input logic              main_wp_n,
   input logic              ctl_busy,
   input logic              vpp_ok,
   input logic              sts_clr,
   input logic              grant,
   input logic              ignore,
   input logic              verr,
   input logic              verr_sticky
);
   logic rst_n;
   logic pe;
   logic top_hit;
   assign rst_n   = rst_if_n & rst_cpu_n;
   assign pe      = req_vld && (req_kind == 2'd0 || req_kind == 2'd1);
   assign top_hit = &req_addr[ADDR_W-1 -: BLK_W];

   a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> $onehot({grant, ignore, verr}));

   a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !(grant || ignore || verr));

   a_r6_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      (pe && ctl_busy) |=> ignore);

   a_r6_suspend_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_kind == 2'd2 && ctl_busy) |=> grant);

   a_r2_top_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (pe && !ctl_busy && top_hit && !top_lock_n) |=> ignore);

   a_r3_main_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (pe && !ctl_busy && !top_hit && !main_wp_n) |=> ignore);

   a_r5_vpp_nogrant: assert property (@(posedge clk) disable iff (!rst_n)
      (pe && !vpp_ok) |=> !grant);

   a_r8_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
      verr |-> verr_sticky);

   a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (verr_sticky && !sts_clr) |=> verr_sticky);

   a_r9_reset_clears: assert property (@(posedge clk)
      !rst_n |=> !(grant || ignore || verr || verr_sticky));
endmodule

bind fwp_gate fwp_gate_chk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_chk (
   .clk         (clk),
   .rst_if_n    (rst_if_n),
   .rst_cpu_n   (rst_cpu_n),
   .req_vld     (req_vld),
   .req_kind    (req_kind),
   .req_addr    (req_addr),
   .top_lock_n  (top_lock_n),
   .main_wp_n   (main_wp_n),
   .ctl_busy    (ctl_busy),
   .vpp_ok      (vpp_ok),
   .sts_clr     (sts_clr),
   .grant       (grant),
   .ignore      (ignore),
   .verr        (verr),
   .verr_sticky (verr_sticky)
);

// File: tb/fwp_gate_bench.sv
module fwp_gate_bench;
   logic        clk = 1'b0;
   logic        rst_if_n = 1'b0, rst_cpu_n = 1'b0;
   logic        req_vld = 1'b0;
   logic [1:0]  req_kind = 2'd0;
   logic [17:0] req_addr = '0;
   logic        top_lock_n = 1'b1, main_wp_n = 1'b1;
   logic        lock_we = 1'b0;
   logic [3:0]  lock_wdata = '0;
   logic        vpp_ok = 1'b1, ctl_busy = 1'b0, sts_clr = 1'b0;
   logic        grant, ignore, verr, verr_sticky;
   logic [17:0] grant_addr;

   int n_chk = 0;
   int n_bad = 0;

   localparam logic [1:0] PROG = 2'd0, ERASE = 2'd1, SUSP = 2'd2, RSVD = 2'd3;
   localparam int G = 1, I = 2, E = 3;

   always #5ns clk = ~clk;

   fwp_gate u_fwp_gate (
      .clk(clk), .rst_if_n(rst_if_n), .rst_cpu_n(rst_cpu_n),
      .req_vld(req_vld), .req_kind(req_kind), .req_addr(req_addr),
      .top_lock_n(top_lock_n), .main_wp_n(main_wp_n),
      .lock_we(lock_we), .lock_wdata(lock_wdata),
      .vpp_ok(vpp_ok), .ctl_busy(ctl_busy), .sts_clr(sts_clr),
      .grant(grant), .grant_addr(grant_addr), .ignore(ignore),
      .verr(verr), .verr_sticky(verr_sticky)
   );

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int outc();
      return {29'd0, verr, ignore, grant} == 32'd1 ? G :
             {29'd0, verr, ignore, grant} == 32'd2 ? I :
             {29'd0, verr, ignore, grant} == 32'd4 ? E : 0;
   endfunction

   task automatic req(logic [1:0] k, logic [1:0] blk, string tag, int exp);
      @(negedge clk);
      req_vld = 1'b1; req_kind = k; req_addr = {blk, 16'h1234};
      @(negedge clk);
      req_vld = 1'b0;
      check(tag, outc(), exp);
      if (exp == G) check({tag, " addr"}, int'(grant_addr), int'({blk, 16'h1234}));
   endtask

   task automatic set_lock(logic [3:0] v);
      @(negedge clk); lock_we = 1'b1; lock_wdata = v;
      @(negedge clk); lock_we = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_if_n = 1'b1; rst_cpu_n = 1'b1;
      check("R9 outputs after reset", int'({grant, ignore, verr, verr_sticky}), 0);
   endtask

   task automatic t_basic();
      for (int b = 0; b < 4; b++) req(PROG, 2'(b), "R1 program unlocked", G);
      req(ERASE, 2'd3, "R1 erase top", G);
   endtask

   task automatic t_pins();
      set_lock(4'b0000);
      top_lock_n = 1'b0;
      req(ERASE, 2'd3, "R2 top pin blocks", I);
      req(PROG, 2'd0, "R2 top pin leaves main", G);
      top_lock_n = 1'b1; main_wp_n = 1'b0;
      req(PROG, 2'd1, "R3 wp blocks main", I);
      req(PROG, 2'd3, "R3 wp leaves top", G);
      main_wp_n = 1'b1;
   endtask

   task automatic t_lock();
      set_lock(4'b0100);
      req(PROG, 2'd2, "R4 locked block", I);
      req(PROG, 2'd1, "R4 unlocked block", G);
      set_lock(4'b1000);
      req(ERASE, 2'd3, "R4 locked top", I);
      set_lock(4'b0000);
   endtask

   task automatic t_vpp();
      vpp_ok = 1'b0;
      req(PROG, 2'd0, "R5 low voltage error", E);
      check("R5 sticky set", int'(verr_sticky), 1);
      main_wp_n = 1'b0;
      req(PROG, 2'd0, "R7 protection before voltage", I);
      main_wp_n = 1'b1;
      vpp_ok = 1'b1;
   endtask

   task automatic t_busy();
      ctl_busy = 1'b1;
      req(PROG, 2'd1, "R6 busy refuses program", I);
      req(SUSP, 2'd1, "R6 suspend while busy", G);
      vpp_ok = 1'b0;
      req(ERASE, 2'd0, "R7 busy before voltage", I);
      vpp_ok = 1'b1; ctl_busy = 1'b0;
      req(SUSP, 2'd0, "R6 suspend while idle", I);
      req(RSVD, 2'd0, "R6 reserved kind", I);
   endtask

   task automatic t_idle();
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         check("R7 no outcome without request", int'({grant, ignore, verr}), 0);
      end
   endtask

   task automatic t_sticky();
      check("R8 sticky held", int'(verr_sticky), 1);
      @(negedge clk); sts_clr = 1'b1;
      @(negedge clk); sts_clr = 1'b0;
      check("R8 clear strobe", int'(verr_sticky), 0);
      vpp_ok = 1'b0;
      @(negedge clk);
      req_vld = 1'b1; req_kind = PROG; req_addr = 18'h0_0010; sts_clr = 1'b1;
      @(negedge clk);
      req_vld = 1'b0; sts_clr = 1'b0; vpp_ok = 1'b1;
      check("R8 error pulse with clear", int'(verr), 1);
      check("R8 set beats clear", int'(verr_sticky), 1);
      @(negedge clk); sts_clr = 1'b1;
      @(negedge clk); sts_clr = 1'b0;
      check("R8 later clear", int'(verr_sticky), 0);
   endtask

   task automatic t_late_pin();
      @(negedge clk);
      req_vld = 1'b1; req_kind = PROG; req_addr = 18'h2_0456;
      @(posedge clk); #1ns;
      main_wp_n = 1'b0; vpp_ok = 1'b0;
      @(negedge clk);
      req_vld = 1'b0;
      check("R10 late pin change", outc(), G);
      check("R10 grant address", int'(grant_addr), 32'h2_0456);
      main_wp_n = 1'b1; vpp_ok = 1'b1;
   endtask

   task automatic t_reset_src();
      set_lock(4'b0001);
      vpp_ok = 1'b0;
      req(PROG, 2'd1, "R5 error before reset", E);
      vpp_ok = 1'b1;
      @(negedge clk); rst_cpu_n = 1'b0;
      @(negedge clk); rst_cpu_n = 1'b1;
      check("R9 cpu reset clears sticky", int'(verr_sticky), 0);
      req(PROG, 2'd0, "R9 cpu reset unlocks", G);
      set_lock(4'b0010);
      @(negedge clk); rst_if_n = 1'b0;
      @(negedge clk); rst_if_n = 1'b1;
      req(PROG, 2'd1, "R9 interface reset unlocks", G);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_pins();
      t_lock();
      t_vpp();
      t_busy();
      t_idle();
      t_sticky();
      t_late_pin();
      t_reset_src();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #200us;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule